// File: doc/BRIEF.md
# Two-Wire Serial Byte Store (16 x 8)

This block is a slave on a two-wire serial bus made of a clock line and a data line. It holds a 16-entry by 8-bit storage array. A fast system clock samples both bus lines. The block watches for a start marker, then takes in one control byte that carries a two-bit command and a four-bit address. Depending on the command, it either accepts one data byte and commits it to the addressed entry, or sends the addressed entry back to the bus master.

There are no acknowledge bits. The data line is driven push-pull through an output enable, so a driven bit is actively high or actively low. After each committed write, a counter holds the block busy for a fixed number of system clocks, and the block ignores the bus for that whole interval.

Top module: `twowire_mem16`

## Requirements
- R1: A falling data line while the clock line is high is a start marker and begins a control byte from any idle point. A rising data line while the clock line is high is a stop marker and returns a partly received control byte to idle. Both lines pass through a two-flop synchronizer before any edge is detected.
- R2: The control byte is taken MSB first, one bit on each rising clock-line edge. Its top two bits are the command (01 = write, 10 = read), the next four are the address (bit 5 is the address MSB, bit 2 the LSB), and the last two are ignored.
- R3: After a write control byte, eight further rising edges shift in a data byte MSB first. On the eighth edge, that byte is stored at the addressed entry.
- R4: A start marker seen before the last write data bit abandons the write and begins a new control byte. A stop marker at that point abandons it and waits for a start. In both cases the entry keeps its old value.
- R5: For BUSY_CYCLES system clocks after a write commits, every bus activity (including starts, stops and commands) is ignored and the output enable stays low.
- R6: After a read control byte, the addressed entry is driven out MSB first. The output enable rises, and the first bit is presented, on the falling clock-line edge that ends the control byte. Each later bit changes only after a falling clock-line edge.
- R7: While read data is being driven, start and stop markers are ignored and the byte continues unchanged.
- R8: Once all eight control bits have been taken, start and stop markers are ignored until the clock line falls again.
- R9: On the eighth rising edge of read data, the output enable drops and the block goes idle, so a start that immediately follows is accepted.
- R10: While enabled, the data output drives both logic levels: a stored 1 bit reads as a high level and a stored 0 bit as a low level.
- R11: A control byte with command 00 or 11 returns the block to idle. It causes no output and no store.
- R12: The synchronous active-low reset clears the sequencer, the output enable and the busy interval, and leaves the stored array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line from the master |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_out | output | 1 | Data bit driven onto the bus |
| sda_oe | output | 1 | Output enable for sda_out (1 = block drives the line) |

## Verification
The bench aims at the windows in which markers must be ignored. A stop is placed in the high phase of the last control clock, and a start is placed in the middle of read output. A block that honoured either marker would lose the write, or would turn off its output part way through the byte. Writes are abandoned both by a restart and by a stop after only a few data bits. A design that committed early would overwrite the entry. A read attempt and a write attempt are issued inside the busy interval, and invalid commands are sent. Any output enable, or any changed entry, in those cases shows that the bus was not shut out. Reset is applied mid-write and just after a commit, to show that the array is kept while the busy interval is dropped.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire byte store.
// Assumes: command codes sit in the two most significant control bits.
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WDATA,
        ST_RDATA,
        ST_BUSY
    } tw_state_e;

    localparam logic [1:0] CMD_WR = 2'b01;
    localparam logic [1:0] CMD_RD = 2'b10;
endpackage

// File: rtl/tw_sync_edge.sv
// Synchronizes both bus lines into the system clock domain and flags
// clock-line edges plus start and stop markers.
// Assumes: bus idles high; STAGES >= 2.
module tw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    localparam int PW = STAGES + 1;

    logic [1:0] line_in;
    logic [1:0] cur;
    logic [1:0] prev;

    assign line_in = {sda_in, scl_in};

    for (genvar i = 0; i < 2; i++) begin : g_line
        logic [PW-1:0] pipe;
        // Shift one bus line through the synchronizer plus one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[PW-2:0], line_in[i]};
        end
        assign cur[i]  = pipe[STAGES-1];
        assign prev[i] = pipe[STAGES];
    end

    assign scl_rise  = cur[0] & ~prev[0];
    assign scl_fall  = ~cur[0] & prev[0];
    assign sda_lvl   = cur[1];
    assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/tw_busy_timer.sv
// Counts out the self-timed write interval after a commit.
// Assumes: load is a single-cycle pulse.
module tw_busy_timer #(
    parameter int CYCLES = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Reload on commit, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= CW'(CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/tw_byte_array.sv
// Storage array with one synchronous write port and one combinational read.
// Assumes: contents survive reset; rst_n only gates the check.
module tw_byte_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/twowire_mem16.sv
// Two-wire bus slave in front of a small byte array: start/stop detection,
// control byte decode, one-byte write with busy interval, one-byte read.
// Assumes: bus lines are asynchronous to clk and much slower than it.
module twowire_mem16
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 625000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out,
    output logic sda_oe
);
    localparam int KEY_W  = 2 + ADDR_W;
    localparam int CTRL_W = KEY_W + 2;
    localparam int MAXB   = (CTRL_W > DATA_W) ? CTRL_W : DATA_W;
    localparam int CNT_W  = $clog2(MAXB + 1);

    tw_state_e         state;
    logic [CNT_W-1:0]  cnt_q;
    logic [KEY_W-1:0]  ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              oe_q;

    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic we, tmr_busy;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        cmd;

    tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det)
    );

    tw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(we), .busy(tmr_busy)
    );

    tw_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(addr_q),
        .wdata({data_q[DATA_W-2:0], sda_lvl}),
        .raddr(ctrl_q[ADDR_W-1:0]), .rdata(rdata)
    );

    assign cmd = ctrl_q[KEY_W-1 -: 2];

    // Commit strobe: last write data bit arrives.
    assign we = (state == ST_WDATA) && scl_rise && (cnt_q == CNT_W'(DATA_W - 1));

    // Bus sequencer: control byte, data phase, busy hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt_q  <= '0;
            ctrl_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_det) begin
                        state <= ST_CTRL;
                        cnt_q <= '0;
                    end
                end
                ST_CTRL: begin
                    if (cnt_q != CNT_W'(CTRL_W) && start_det) begin
                        cnt_q <= '0;
                    end else if (cnt_q != CNT_W'(CTRL_W) && stop_det) begin
                        state <= ST_IDLE;
                    end else if (scl_rise && cnt_q != CNT_W'(CTRL_W)) begin
                        if (cnt_q < CNT_W'(KEY_W))
                            ctrl_q <= {ctrl_q[KEY_W-2:0], sda_lvl};
                        cnt_q <= cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == CNT_W'(CTRL_W)) begin
                        cnt_q  <= '0;
                        addr_q <= ctrl_q[ADDR_W-1:0];
                        if (cmd == CMD_WR) begin
                            state <= ST_WDATA;
                        end else if (cmd == CMD_RD) begin
                            state  <= ST_RDATA;
                            data_q <= rdata;
                            oe_q   <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WDATA: begin
                    if (start_det) begin
                        state <= ST_CTRL;
                        cnt_q <= '0;
                    end else if (stop_det) begin
                        state <= ST_IDLE;
                    end else if (scl_rise) begin
                        data_q <= {data_q[DATA_W-2:0], sda_lvl};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(DATA_W - 1)) state <= ST_BUSY;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(DATA_W - 1)) begin
                            state <= ST_IDLE;
                            oe_q  <= 1'b0;
                            cnt_q <= '0;
                        end
                    end else if (scl_fall) begin
                        data_q <= {data_q[DATA_W-2:0], 1'b0};
                    end
                end
                ST_BUSY: begin
                    if (!tmr_busy) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_out = data_q[DATA_W-1];
    assign sda_oe  = oe_q;

    assert_no_drive_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> !tmr_busy);
    assert_busy_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_busy) |-> (state == ST_BUSY));
    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && tmr_busy) |=> (state == ST_BUSY));
    assert_out_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && $past(sda_oe) && !$past(scl_fall)) |-> $stable(sda_out));
    assert_read_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && start_det) |=> (state != ST_CTRL));
    assert_last_ctrl_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && cnt_q == CNT_W'(CTRL_W) && stop_det) |=> (state == ST_CTRL));
endmodule

// File: tb/twowire_mem16_bench.sv
module twowire_mem16_bench;
    localparam int BUSY = 2000;
    localparam int HALF = 16;
    localparam int WAIT_BUSY = BUSY + 200;

    // {op, addr, data}: op 1 = write, op 2 = read (data = expected byte)
    localparam logic [13:0] VEC [10] = '{
        {2'd1, 4'h3, 8'hA5}, {2'd1, 4'hF, 8'h3C}, {2'd1, 4'h0, 8'hFF},
        {2'd1, 4'h7, 8'h00}, {2'd2, 4'h3, 8'hA5}, {2'd2, 4'hF, 8'h3C},
        {2'd2, 4'h0, 8'hFF}, {2'd2, 4'h7, 8'h00}, {2'd1, 4'h3, 8'h5A},
        {2'd2, 4'h3, 8'h5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_out, sda_oe;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   watch = 1'b0;
    bit   oe_seen = 1'b0;

    always #4 clk = ~clk;

    twowire_mem16 #(.BUSY_CYCLES(BUSY)) u_twowire_mem16 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .sda_out(sda_out), .sda_oe(sda_oe)
    );

    always @(negedge clk) if (watch && sda_oe) oe_seen <= 1'b1;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda = 1'b1; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF);
        sda = 1'b0; wait_clk(HALF);
        scl = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF);
        sda = 1'b1; wait_clk(HALF);
    endtask

    // One bit; glitch raises the data line mid high phase (a stop marker).
    task automatic send_bit(input logic b, input bit glitch);
        sda = b; wait_clk(HALF);
        scl = 1'b1; wait_clk(HALF / 2);
        if (glitch) sda = 1'b1;
        wait_clk(HALF / 2);
        scl = 1'b0;
    endtask

    // Sample before the rising edge; glitch drops the data line while high (a start marker).
    task automatic recv_bit(input bit glitch, output logic b, output logic oe);
        sda = 1'b1; wait_clk(HALF);
        b = sda_out; oe = sda_oe;
        scl = 1'b1; wait_clk(HALF / 2);
        if (glitch) sda = 1'b0;
        wait_clk(HALF / 2);
        scl = 1'b0;
    endtask

    task automatic send_ctrl(input logic [1:0] cmd, input logic [3:0] a, input bit glitch8);
        logic [7:0] c;
        c = {cmd, a, 2'b00};
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(c[i], glitch8 && i == 0);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input bit glitch8);
        send_ctrl(2'b01, a, glitch8);
        for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b0);
    endtask

    task automatic do_read(input logic [3:0] a, input int glitch_at,
                           output logic [7:0] d, output bit oe_all);
        logic b, oe;
        send_ctrl(2'b10, a, 1'b0);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(i == glitch_at, b, oe);
            d[i] = b;
            if (!oe) oe_all = 1'b0;
        end
    endtask

    initial begin
        logic [7:0] rd;
        bit oe_all;
        logic b, oe;
        wait_clk(6);
        check(sda_oe == 1'b0, "R12 reset output enable", sda_oe, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // Vector table walk
        for (int v = 0; v < 10; v++) begin
            if (VEC[v][13:12] == 2'd1) begin
                do_write(VEC[v][11:8], VEC[v][7:0], 1'b0);
                wait_clk(WAIT_BUSY);
            end else begin
                do_read(VEC[v][11:8], -1, rd, oe_all);
                check(rd == VEC[v][7:0], "R1 R2 R3 R6 R9 R10 read data", rd, VEC[v][7:0]);
                check(oe_all, "R6 R10 enable while driving", oe_all, 1);
            end
        end
        wait_clk(HALF);
        check(sda_oe == 1'b0, "R9 enable drops after read", sda_oe, 0);

        // R4: restart after five write data bits
        send_ctrl(2'b01, 4'h3, 1'b0);
        for (int i = 7; i >= 3; i--) send_bit(1'b0, 1'b0);
        do_read(4'h3, -1, rd, oe_all);
        check(rd == 8'h5A, "R4 start abort keeps entry", rd, 8'h5A);

        // R4: stop after three write data bits
        send_ctrl(2'b01, 4'hF, 1'b0);
        for (int i = 7; i >= 5; i--) send_bit(1'b1, 1'b0);
        bus_stop();
        do_read(4'hF, -1, rd, oe_all);
        check(rd == 8'h3C, "R4 stop abort keeps entry", rd, 8'h3C);

        // R8: stop marker inside the last control clock is ignored
        do_write(4'h9, 8'h66, 1'b1);
        wait_clk(WAIT_BUSY);
        do_read(4'h9, -1, rd, oe_all);
        check(rd == 8'h66, "R8 write survives stop in last control clock", rd, 8'h66);

        // R7: start marker during read output is ignored
        do_read(4'h9, 4, rd, oe_all);
        check(rd == 8'h66, "R7 read data with start glitch", rd, 8'h66);
        check(oe_all, "R7 enable held through glitch", oe_all, 1);

        // R5: bus shut out during busy interval
        do_write(4'h6, 8'h99, 1'b0);
        oe_seen = 1'b0; watch = 1'b1;
        do_read(4'h6, -1, rd, oe_all);
        do_write(4'h6, 8'h00, 1'b0);
        watch = 1'b0;
        wait_clk(2);
        check(oe_seen == 1'b0, "R5 no drive during busy", oe_seen, 0);
        wait_clk(WAIT_BUSY);
        do_read(4'h6, -1, rd, oe_all);
        check(rd == 8'h99, "R5 write during busy ignored", rd, 8'h99);

        // R11: invalid commands
        oe_seen = 1'b0; watch = 1'b1;
        send_ctrl(2'b11, 4'h6, 1'b0);
        for (int i = 7; i >= 0; i--) send_bit(1'b0, 1'b0);
        send_ctrl(2'b00, 4'h6, 1'b0);
        for (int i = 7; i >= 0; i--) recv_bit(1'b0, b, oe);
        watch = 1'b0;
        wait_clk(2);
        check(oe_seen == 1'b0, "R11 no output on invalid command", oe_seen, 0);
        wait_clk(WAIT_BUSY);
        do_read(4'h6, -1, rd, oe_all);
        check(rd == 8'h99, "R11 no store on invalid command", rd, 8'h99);

        // R12: reset mid-write keeps the array
        send_ctrl(2'b01, 4'h6, 1'b0);
        for (int i = 7; i >= 4; i--) send_bit(1'b0, 1'b0);
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
        wait_clk(6);
        check(sda_oe == 1'b0, "R12 enable low in reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_clk(4);
        do_read(4'h6, -1, rd, oe_all);
        check(rd == 8'h99, "R12 array kept over reset", rd, 8'h99);

        // R12: reset clears busy interval
        do_write(4'h2, 8'h44, 1'b0);
        wait_clk(4);
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);
        do_read(4'h2, -1, rd, oe_all);
        check(rd == 8'h44, "R12 busy cleared by reset", rd, 8'h44);
        check(oe_all, "R12 read enabled right after reset", oe_all, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule